// File: doc/BRIEF.md
# Field-configurable AND-OR logic array

This block is a combinational sum-of-products array. Its whole connection pattern lives in an internal configuration register that is filled one bit per clock through a serial port before the array is used. Eight dedicated inputs and the current values of ten bidirectional pins (18 signals in all) are offered to the AND plane in true and complement form. The plane forms 42 product terms: 32 shared logic terms and 10 enable terms, one per pin. A second plane lets any logic term feed any subset of the ten OR gates. Each OR result then passes through a selectable inversion, and each pin drives only while its own enable term is true.

The same port reads the configuration back by rotating the register, so the pattern survives the read. A lock bit at the end of the stream blocks readback once it is set. Only an erase command clears the lock, and the erase also clears every other configuration bit. The pins are modelled as separate input, output and output-enable vectors. The surrounding logic resolves them to real three-state pads.

Top module: `sop_array`

## Requirements
- R1: Configuration bit `t*36 + 2*s` connects the true literal and bit `t*36 + 2*s + 1` connects the complement literal of signal `s` to product term `t`. Signals 0..7 are `in_pins` and signals 8..17 are `io_in[0..9]`. An unconnected literal contributes 1, so a term with nothing connected is 1, and a term with both literals of one signal connected is 0.
- R2: Output `io_out[o]` (before inversion) is the OR of the logic terms `t` (0..31) whose bit `1512 + t*10 + o` is set. An output with no connected term is 0.
- R3: Bit `1832 + o` set inverts `io_out[o]` (active-low), and clear leaves it active-high.
- R4: When the port is idle, `io_oe[j]` equals product term `32 + j`.
- R5: `io_in` feeds the AND plane whether or not the corresponding pin is enabled, so a pin's value can feed back into the array.
- R6: While `cfg_load` is high, each clock shifts `cfg_sdi` into the register. After 1843 clocks, the first bit sent sits at bit 0 and the last at bit 1842. Bits 0..1511 are the AND plane, then the OR plane, then 10 inversion bits, then the lock bit. With the port idle the configuration does not change.
- R7: While `cfg_load` or `cfg_read` is high, every `io_oe` bit is 0.
- R8: While `cfg_read` is high (and `cfg_load` low), each clock rotates the register by one place, bit 0 moving to the top. When unlocked, `cfg_sdo` shows bit 0, so reading 1843 clocks returns the stream in load order and leaves the configuration as it was.
- R9: When `cfg_load` falls and bit 1842 is 1, the lock engages on that clock. While locked, `cfg_sdo` is 0, and later loads do not release the lock.
- R10: `cfg_erase` clears every configuration bit and the lock on the next clock. It takes priority over a load or read in the same cycle.
- R11: After reset the configuration is all zero and unlocked. With the port idle, `io_out` is all 0 and `io_oe` is all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration port |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Shift serial data into the configuration |
| cfg_read | input | 1 | Rotate the configuration for readback |
| cfg_erase | input | 1 | Clear the configuration and the lock |
| cfg_sdi | input | 1 | Serial configuration data in |
| cfg_sdo | output | 1 | Serial readback data, 0 while locked |
| in_pins | input | 8 | Dedicated array inputs |
| io_in | input | 10 | Observed values of the bidirectional pins |
| io_out | output | 10 | Array results for the bidirectional pins |
| io_oe | output | 10 | Per-pin driver enables |

## Verification
The assertions assume that `cfg_sdi` and the three port commands are known at every clock edge after reset, and that a read is meaningful only when no load is active. The bench holds all port inputs at defined values from time zero and changes them only on the falling edge. It never raises `cfg_read` during a load, except in the one directed case where an erase is overlapped with a load. The pin inputs are driven either at random or, for feedback, from the enabled outputs of the previous cycle. This keeps `io_in` free of any combinational loop through the block.

// File: rtl/sop_array.sv
module sop_array #(
  parameter int N_IN = 8,
  parameter int N_IO = 10,
  parameter int N_PT = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_load,
  input  logic            cfg_read,
  input  logic            cfg_erase,
  input  logic            cfg_sdi,
  output logic            cfg_sdo,
  input  logic [N_IN-1:0] in_pins,
  input  logic [N_IO-1:0] io_in,
  output logic [N_IO-1:0] io_out,
  output logic [N_IO-1:0] io_oe
);
  localparam int N_SIG    = N_IN + N_IO;
  localparam int ROW      = 2 * N_SIG;
  localparam int N_TERM   = N_PT + N_IO;
  localparam int OR_BASE  = N_TERM * ROW;
  localparam int POL_BASE = OR_BASE + N_PT * N_IO;
  localparam int LOCK_BIT = POL_BASE + N_IO;
  localparam int CFG_W    = LOCK_BIT + 1;

  logic [CFG_W-1:0]  cfg;
  logic              lock_q, load_d;
  logic [N_SIG-1:0]  sig;
  logic [ROW-1:0]    lit;
  logic [N_TERM-1:0] pt;
  logic [N_IO-1:0]   sum;

  assign sig = {io_in, in_pins};

  genvar gs, gt, go, gk;
  generate
    for (gs = 0; gs < N_SIG; gs++) begin : g_lit
      assign lit[2*gs]   = ~sig[gs];
      assign lit[2*gs+1] =  sig[gs];
    end
    for (gt = 0; gt < N_TERM; gt++) begin : g_term
      assign pt[gt] = ~|(cfg[gt*ROW +: ROW] & lit);
    end
    for (go = 0; go < N_IO; go++) begin : g_or
      logic [N_PT-1:0] col;
      for (gk = 0; gk < N_PT; gk++) begin : g_bit
        assign col[gk] = cfg[OR_BASE + gk*N_IO + go];
      end
      assign sum[go] = |(col & pt[N_PT-1:0]);
    end
  endgenerate

  assign io_out  = sum ^ cfg[POL_BASE +: N_IO];
  assign io_oe   = (cfg_load | cfg_read) ? '0 : pt[N_PT +: N_IO];
  assign cfg_sdo = ~lock_q & cfg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      lock_q <= 1'b0;
      load_d <= 1'b0;
    end else begin
      load_d <= cfg_load;
      if (cfg_erase) begin
        cfg    <= '0;
        lock_q <= 1'b0;
      end else begin
        if (cfg_load)      cfg <= {cfg_sdi, cfg[CFG_W-1:1]};
        else if (cfg_read) cfg <= {cfg[0], cfg[CFG_W-1:1]};
        if (load_d && !cfg_load && cfg[LOCK_BIT]) lock_q <= 1'b1;
      end
    end
  end

  p_erase_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_erase |=> (cfg == '0 && !lock_q));
  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !cfg_erase) |=> lock_q);
  p_load_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && !cfg_erase) |=> cfg[CFG_W-1] == $past(cfg_sdi));
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_load && !cfg_read && !cfg_erase) |=> $stable(cfg));
  p_read_rotate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_read && !cfg_load && !cfg_erase) |=> cfg[CFG_W-1] == $past(cfg[0]));
endmodule

// File: tb/sop_array_bench.sv
`timescale 1ns/1ps
module sop_array_bench;
  localparam int NI = 8, NO = 10, NP = 32;
  localparam int NS = NI + NO, RW = 2 * NS, NT = NP + NO;
  localparam int ORB = NT * RW, POLB = ORB + NP * NO, LCK = POLB + NO, TOT = LCK + 1;

  logic clk = 0, rst_n = 0;
  logic load_v = 0, read_v = 0, erase_v = 0, sdi_v = 0;
  logic [NI-1:0] in_v = '0;
  logic [NO-1:0] io_v = '0;
  logic sdo;
  logic [NO-1:0] out, oe;
  int checks = 0, errors = 0;
  bit done = 0;
  bit img [TOT];
  bit m_cfg [TOT];
  bit m_lock = 0, m_load_d = 0;

  always #4 clk = ~clk;

  sop_array u_sop_array (
    .clk(clk), .rst_n(rst_n), .cfg_load(load_v), .cfg_read(read_v), .cfg_erase(erase_v),
    .cfg_sdi(sdi_v), .cfg_sdo(sdo), .in_pins(in_v), .io_in(io_v), .io_out(out), .io_oe(oe));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_cfg[i]) m_cfg[i] = 0;
      m_lock = 0; m_load_d = 0;
    end else begin
      bit fell;
      fell = m_load_d && !load_v && m_cfg[LCK];
      m_load_d = load_v;
      if (erase_v) begin
        foreach (m_cfg[i]) m_cfg[i] = 0;
        m_lock = 0;
      end else begin
        if (load_v || read_v) begin
          bit nb;
          nb = load_v ? sdi_v : m_cfg[0];
          for (int i = 0; i < TOT - 1; i++) m_cfg[i] = m_cfg[i+1];
          m_cfg[TOT-1] = nb;
        end
        if (fell) m_lock = 1;
      end
    end
  end

  task automatic model(output logic [NO-1:0] eo, output logic [NO-1:0] eoe);
    bit p [NT];
    for (int t = 0; t < NT; t++) begin
      p[t] = 1;
      for (int s = 0; s < NS; s++) begin
        bit x;
        x = (s < NI) ? in_v[s] : io_v[s-NI];
        if (m_cfg[t*RW + 2*s] && !x) p[t] = 0;
        if (m_cfg[t*RW + 2*s + 1] && x) p[t] = 0;
      end
    end
    for (int o = 0; o < NO; o++) begin
      bit acc;
      acc = 0;
      for (int t = 0; t < NP; t++) if (p[t] && m_cfg[ORB + t*NO + o]) acc = 1;
      eo[o] = acc ^ m_cfg[POLB + o];
      eoe[o] = (load_v || read_v) ? 1'b0 : p[NP + o];
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      logic [NO-1:0] eo, eoe;
      model(eo, eoe);
      check("R2 R3 R5 io_out vs model", 32'(out), 32'(eo));
      check("R4 R7 io_oe vs model", 32'(oe), 32'(eoe));
      check("R8 R9 cfg_sdo vs model", 32'(sdo), 32'(m_lock ? 1'b0 : m_cfg[0]));
    end
  end

  task automatic clear_img();
    foreach (img[i]) img[i] = 0;
  endtask
  task automatic set_and(input int t, input int s, input bit comp);
    img[t*RW + 2*s + (comp ? 1 : 0)] = 1;
  endtask
  task automatic rand_img(input bit lk);
    for (int i = 0; i < TOT; i++) begin
      if (i < ORB) img[i] = ($urandom % 14) == 0;
      else if (i < POLB) img[i] = ($urandom % 3) == 0;
      else img[i] = $urandom % 2;
    end
    img[LCK] = lk;
  endtask

  task automatic load_img();
    for (int i = 0; i < TOT; i++) begin
      @(negedge clk);
      load_v = 1; sdi_v = img[i];
      if (i == TOT / 2) begin
        #2;
        check("R7 io_oe low during load", 32'(oe), 32'(0));
      end
    end
    @(negedge clk);
    load_v = 0; sdi_v = 0;
  endtask

  task automatic read_back(input bit expect_zero, input string tag);
    for (int i = 0; i < TOT; i++) begin
      @(negedge clk);
      read_v = 1;
      #2;
      check(tag, 32'(sdo), 32'(expect_zero ? 1'b0 : img[i]));
    end
    @(negedge clk);
    read_v = 0;
  endtask

  task automatic apply(input logic [NI-1:0] a, input logic [NO-1:0] b);
    @(negedge clk);
    in_v = a; io_v = b;
    #2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    apply('0, '0);
    check("R11 reset io_out", 32'(out), 32'(0));
    check("R11 reset io_oe", 32'(oe), 32'(10'h3FF));
    check("R11 reset cfg_sdo", 32'(sdo), 32'(0));

    clear_img(); set_and(0, 0, 0); img[ORB + 0*NO + 0] = 1;
    load_img();
    apply(8'h01, '0);
    check("R1 R6 true literal passes", 32'(out[0]), 32'(1));
    check("R2 unconnected OR is 0", 32'(out[1]), 32'(0));
    apply(8'h00, '0);
    check("R1 true literal blocks", 32'(out[0]), 32'(0));
    set_and(0, 0, 1);
    load_img();
    apply(8'h01, '0);
    check("R1 both literals give 0", 32'(out[0]), 32'(0));

    clear_img(); set_and(0, 0, 0); img[ORB] = 1; img[POLB] = 1; img[POLB + 1] = 1;
    load_img();
    apply(8'h01, '0);
    check("R3 inverted active term", 32'(out[0]), 32'(0));
    check("R3 inverted empty sum", 32'(out[1]), 32'(1));

    clear_img(); set_and(NP + 3, 1, 1);
    load_img();
    apply(8'h00, '0);
    check("R4 enable term true", 32'(oe[3]), 32'(1));
    apply(8'h02, '0);
    check("R4 enable term false", 32'(oe), 32'(10'h3F7));

    clear_img(); set_and(1, NI + 2, 0); img[ORB + 1*NO + 5] = 1; set_and(NP + 2, 0, 0);
    load_img();
    apply(8'h00, 10'h004);
    check("R5 disabled pin still feeds array", 32'(out[5]), 32'(1));
    check("R5 pin disabled", 32'(oe[2]), 32'(0));
    apply(8'h00, 10'h000);
    check("R5 pin low", 32'(out[5]), 32'(0));

    rand_img(0);
    load_img();
    read_back(0, "R8 readback bit");
    apply(8'h5A, 10'h2C3);
    read_back(0, "R8 readback preserved");

    rand_img(1);
    load_img();
    read_back(1, "R9 locked readback");
    rand_img(0);
    load_img();
    read_back(1, "R9 lock survives reload");

    @(negedge clk);
    erase_v = 1; load_v = 1; sdi_v = 1;
    @(negedge clk);
    erase_v = 0; load_v = 0; sdi_v = 0;
    apply('0, '0);
    check("R10 erase clears io_out", 32'(out), 32'(0));
    check("R10 erase clears enables", 32'(oe), 32'(10'h3FF));
    rand_img(0);
    load_img();
    read_back(0, "R10 lock cleared by erase");

    for (int c = 0; c < 6; c++) begin
      rand_img(0);
      load_img();
      for (int k = 0; k < 150; k++) begin
        @(negedge clk);
        in_v = NI'($urandom);
        if (k % 2 == 1) io_v = (oe & out) | (~oe & NO'($urandom));
        else io_v = NO'($urandom);
      end
    end

    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule